// File: doc/BRIEF.md
# Multiphase Local-Oscillator Generator with Serial Phase Programming

This block drives eight local-oscillator outputs, one per receive channel. Each output is a square wave at a fraction of a fast reference, and each has its own programmable phase offset. Two mode pins select the operating mode:

- divide by 16, giving 16 phase steps;
- divide by 8, giving 8 phase steps;
- divide by 4, giving 4 phase steps;
- a bypass in which an externally supplied quadrature clock per channel is passed straight through.

In the two finer modes one shared reference advances every channel. In the divide-by-4 and bypass modes each channel follows its own input.

The whole block is synchronous to one system clock `clk`. The references arrive as single-cycle advance enables (`ref_tick` and `ch_ref_tick`). The serial shift clock arrives as a shift enable (`ser_shift`).

Configuration is shifted into a 40-bit shadow chain and becomes active only on a load strobe. Each channel has a 5-bit word holding a 4-bit phase code and a shutdown flag. After every load, and after every change of the mode pins, each channel's divide counter is preset to its phase code on the next reference advance. This gives the channels a fixed relative phase.

Top module: `lo_phase_gen`

## Requirements
- R1: Mode pins `{mode_a, mode_b}` decode as follows: 00 divides by N=16 and every channel advances on `ref_tick`; 01 divides by N=8 with `ref_tick`; 10 divides by N=4 and channel i advances on `ch_ref_tick[i]`; 11 is bypass.
- R2: Each cycle with `ser_shift` high moves `ser_data` into the LSB of the 40-bit shadow chain, and the older bits move up one place. After 40 shifts:
  - the first bit sent sits at chain bit 39;
  - channel c's word occupies chain bits [5c+4 : 5c];
  - word bits [4:1] are the phase code with bit 4 as its MSB (sent first);
  - word bit 0 is the shutdown flag (sent last).
- R3: The active configuration changes only at a clock edge with `ser_load` high, where it takes the shadow chain's value from before that edge. Shifting without a load leaves every output unchanged.
- R4: After a load, or after the mode pins change, each channel's counter is set to its phase code (masked as in R6) on that channel's next advance. Every later advance increments it modulo N. After a preset and k further advances, the count is (code mod N + k) mod N.
- R5: In modes 00, 01 and 10, an enabled channel's output is high exactly when its count is at least N/2, giving a 50% duty cycle.
- R6: Phase code bits that the mode cannot use are ignored: the MSB in mode 01, and the two MSBs in mode 10.
- R7: A shutdown flag of 1 holds that channel's output low in every mode. A flag of 0 enables the channel.
- R8: In mode 10, a channel whose `ch_ref_tick` bit is low keeps its count, whatever the other channels do.
- R9: In mode 11, `lo_out[i]` equals `quad_clk[i]` when channel i is enabled.
- R10: Reset clears the shadow chain and makes every channel's active word phase 0 with shutdown 1, so all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_a | input | 1 | Mode select, upper bit |
| mode_b | input | 1 | Mode select, lower bit |
| ser_data | input | 1 | Serial configuration data |
| ser_shift | input | 1 | Shift enable for the shadow chain |
| ser_load | input | 1 | Copies the shadow chain into the active configuration |
| ref_tick | input | 1 | Shared reference advance (modes 00 and 01) |
| ch_ref_tick | input | 8 | Per-channel reference advance (mode 10) |
| quad_clk | input | 8 | Per-channel external quadrature clock (mode 11) |
| lo_out | output | 8 | Per-channel LO outputs |

## Verification
The bench walks a table of modes, phase codes, shutdown masks and advance counts. It compares all eight outputs against the modulo arithmetic of R4 and R5. This catches a wrong divide ratio or an off-by-one preset, because either one shifts the edge at which an output goes high. Codes with set upper bits are run in the coarse modes: a design that fails to mask them would start from the wrong count. A single-enabled-channel pattern exposes a reversed chain order, since the output would then appear on channel 7 instead of channel 0. Further directed tests cover the following: shifting without a load; a mode change with no reload, which must re-preset the counters; a lone channel advancing in mode 10; and bypass gating by shutdown.

// File: rtl/lo_phase_pkg.sv
package lo_phase_pkg;

    localparam int PHASE_W  = 4;
    localparam int WORD_W   = PHASE_W + 1;
    localparam int SEL_W    = $clog2(PHASE_W);
    localparam int DEF_NCH  = 8;

    typedef enum logic [1:0] {
        MODE_DIV16  = 2'b00,
        MODE_DIV8   = 2'b01,
        MODE_DIV4   = 2'b10,
        MODE_BYPASS = 2'b11
    } lo_mode_e;

endpackage

// File: rtl/lo_mode_decode.sv
module lo_mode_decode
    import lo_phase_pkg::*;
(
    input  lo_mode_e             mode,
    output logic [PHASE_W-1:0]   cnt_mask,
    output logic [SEL_W-1:0]     msb_sel,
    output logic                 shared_ref,
    output logic                 bypass
);

    always_comb begin
        cnt_mask   = '1;
        msb_sel    = SEL_W'(PHASE_W - 1);
        shared_ref = 1'b1;
        bypass     = 1'b0;
        unique case (mode)
            MODE_DIV16: begin
                cnt_mask = '1;
                msb_sel  = SEL_W'(PHASE_W - 1);
            end
            MODE_DIV8: begin
                cnt_mask = PHASE_W'({(PHASE_W-1){1'b1}});
                msb_sel  = SEL_W'(PHASE_W - 2);
            end
            MODE_DIV4: begin
                cnt_mask   = PHASE_W'({(PHASE_W-2){1'b1}});
                msb_sel    = SEL_W'(PHASE_W - 3);
                shared_ref = 1'b0;
            end
            MODE_BYPASS: begin
                cnt_mask   = PHASE_W'({(PHASE_W-2){1'b1}});
                msb_sel    = SEL_W'(PHASE_W - 3);
                shared_ref = 1'b0;
                bypass     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lo_cfg_chain.sv
module lo_cfg_chain
    import lo_phase_pkg::*;
#(
    parameter int NUM_CH = DEF_NCH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic                        sdata,
    input  logic                        load,
    output logic [NUM_CH*WORD_W-1:0]    shadow,
    output logic [NUM_CH*WORD_W-1:0]    active
);

    localparam int CFG_W = NUM_CH * WORD_W;
    localparam logic [WORD_W-1:0] WORD_RST = WORD_W'(1);

    typedef struct packed {
        logic [CFG_W-1:0] shadow;
        logic [CFG_W-1:0] active;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.shadow = {st_q.shadow[CFG_W-2:0], sdata};
        end
        if (load) begin
            st_d.active = st_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= '0;
            st_q.active <= {NUM_CH{WORD_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow = st_q.shadow;
    assign active = st_q.active;

endmodule

// File: rtl/lo_chan_div.sv
module lo_chan_div
    import lo_phase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 resync,
    input  logic [PHASE_W-1:0]   phase,
    input  logic                 off,
    input  logic [PHASE_W-1:0]   cnt_mask,
    input  logic [SEL_W-1:0]     msb_sel,
    input  logic                 bypass,
    input  logic                 quad_in,
    output logic                 lo,
    output logic [PHASE_W-1:0]   cnt
);

    typedef struct packed {
        logic [PHASE_W-1:0] cnt;
        logic               pend;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.pend) begin
                st_d.cnt = phase & cnt_mask;
            end else begin
                st_d.cnt = (st_q.cnt + 1'b1) & cnt_mask;
            end
            st_d.pend = 1'b0;
        end
        if (resync) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    logic div_bit;
    assign div_bit = st_q.cnt[msb_sel];
    assign lo      = ~off & (bypass ? quad_in : div_bit);
    assign cnt     = st_q.cnt;

endmodule

// File: rtl/lo_phase_gen.sv
module lo_phase_gen
    import lo_phase_pkg::*;
#(
    parameter int NUM_CH = DEF_NCH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_a,
    input  logic               mode_b,
    input  logic               ser_data,
    input  logic               ser_shift,
    input  logic               ser_load,
    input  logic               ref_tick,
    input  logic [NUM_CH-1:0]  ch_ref_tick,
    input  logic [NUM_CH-1:0]  quad_clk,
    output logic [NUM_CH-1:0]  lo_out
);

    localparam int CFG_W = NUM_CH * WORD_W;
    localparam int CNT_W = NUM_CH * PHASE_W;

    typedef struct packed {
        lo_mode_e mode;
    } top_st_t;

    top_st_t  st_d, st_q;
    lo_mode_e mode_pins;
    logic     resync;

    always_comb begin
        mode_pins = lo_mode_e'({mode_a, mode_b});
        st_d      = st_q;
        st_d.mode = mode_pins;
        resync    = ser_load | (mode_pins != st_q.mode);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_DIV16;
        end else begin
            st_q <= st_d;
        end
    end

    logic [1:0]          mode_q;
    logic [PHASE_W-1:0]  cnt_mask;
    logic [SEL_W-1:0]    msb_sel;
    logic                shared_ref;
    logic                bypass;
    logic [CFG_W-1:0]    shadow_q;
    logic [CFG_W-1:0]    act_cfg;
    logic [CNT_W-1:0]    cnt_all;

    assign mode_q = st_q.mode;

    lo_mode_decode u_dec (
        .mode       (st_q.mode),
        .cnt_mask   (cnt_mask),
        .msb_sel    (msb_sel),
        .shared_ref (shared_ref),
        .bypass     (bypass)
    );

    lo_cfg_chain #(.NUM_CH(NUM_CH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ser_shift),
        .sdata    (ser_data),
        .load     (ser_load),
        .shadow   (shadow_q),
        .active   (act_cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ch_tick;
        assign ch_tick = shared_ref ? ref_tick : ch_ref_tick[i];

        lo_chan_div u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ch_tick),
            .resync   (resync),
            .phase    (act_cfg[i*WORD_W+1 +: PHASE_W]),
            .off      (act_cfg[i*WORD_W]),
            .cnt_mask (cnt_mask),
            .msb_sel  (msb_sel),
            .bypass   (bypass),
            .quad_in  (quad_clk[i]),
            .lo       (lo_out[i]),
            .cnt      (cnt_all[i*PHASE_W +: PHASE_W])
        );
    end

endmodule

// File: rtl/lo_phase_chk.sv
module lo_phase_chk
    import lo_phase_pkg::*;
#(
    parameter int NUM_CH = DEF_NCH
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  mode_q,
    input logic                        ser_shift,
    input logic                        ser_data,
    input logic                        ser_load,
    input logic [NUM_CH*WORD_W-1:0]    shadow_q,
    input logic [NUM_CH*WORD_W-1:0]    act_cfg,
    input logic [NUM_CH*PHASE_W-1:0]   cnt_all,
    input logic [NUM_CH-1:0]           ch_ref_tick,
    input logic [NUM_CH-1:0]           quad_clk,
    input logic [NUM_CH-1:0]           lo_out
);

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_shift |=> shadow_q[0] == $past(ser_data));

    assert_hold_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_load |=> $stable(act_cfg));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            act_cfg[i*WORD_W] |-> !lo_out[i]);

        assert_own_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == 2'b10 && !ch_ref_tick[i]) |=> $stable(cnt_all[i*PHASE_W +: PHASE_W]));

        assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == 2'b11 && !act_cfg[i*WORD_W]) |-> lo_out[i] == quad_clk[i]);
    end

endmodule

bind lo_phase_gen lo_phase_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .ser_shift   (ser_shift),
    .ser_data    (ser_data),
    .ser_load    (ser_load),
    .shadow_q    (shadow_q),
    .act_cfg     (act_cfg),
    .cnt_all     (cnt_all),
    .ch_ref_tick (ch_ref_tick),
    .quad_clk    (quad_clk),
    .lo_out      (lo_out)
);

// File: tb/tb_lo_phase_gen.sv
module tb_lo_phase_gen;

    localparam int NCH = 8;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] base;
        logic [7:0] offm;
        logic [4:0] steps;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 4'd0,  8'h00, 5'd0},
        '{2'd0, 4'd5,  8'h00, 5'd7},
        '{2'd0, 4'd9,  8'hA5, 5'd13},
        '{2'd1, 4'd12, 8'h00, 5'd3},
        '{2'd1, 4'd7,  8'h0F, 5'd10},
        '{2'd2, 4'd14, 8'h00, 5'd1},
        '{2'd2, 4'd3,  8'h81, 5'd6},
        '{2'd0, 4'd15, 8'hFF, 5'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_a = 1'b0, mode_b = 1'b0;
    logic ser_data = 1'b0, ser_shift = 1'b0, ser_load = 1'b0;
    logic ref_tick = 1'b0;
    logic [NCH-1:0] ch_ref_tick = '0;
    logic [NCH-1:0] quad_clk = '0;
    logic [NCH-1:0] lo_out;

    int checks = 0;
    int fails  = 0;
    logic [3:0] cur_code [NCH];
    logic       cur_off  [NCH];
    int         cur_steps[NCH];

    always #5 clk = ~clk;

    lo_phase_gen #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .ser_data(ser_data), .ser_shift(ser_shift), .ser_load(ser_load),
        .ref_tick(ref_tick), .ch_ref_tick(ch_ref_tick),
        .quad_clk(quad_clk), .lo_out(lo_out)
    );

    task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: lo_out=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] expect_lo(input logic [1:0] mode);
        logic [NCH-1:0] r;
        int n;
        n = 16 >> mode;
        for (int c = 0; c < NCH; c++) begin
            int cnt;
            cnt = (int'(cur_code[c]) % n + cur_steps[c]) % n;
            r[c] = !cur_off[c] && (cnt >= n / 2);
        end
        return r;
    endfunction

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        {mode_a, mode_b} = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic program_cfg(input logic [3:0] base, input int mul,
                               input logic [7:0] offm, input bit do_load);
        logic [NCH*5-1:0] img;
        for (int c = 0; c < NCH; c++) begin
            logic [3:0] code;
            code = 4'((int'(base) + mul * c) & 15);
            img[c*5 +: 5] = {code, offm[c]};
            if (do_load) begin
                cur_code[c]  = code;
                cur_off[c]   = offm[c];
                cur_steps[c] = 0;
            end
        end
        @(negedge clk);
        for (int b = NCH*5-1; b >= 0; b--) begin
            ser_shift = 1'b1;
            ser_data  = img[b];
            @(negedge clk);
        end
        ser_shift = 1'b0;
        ser_data  = 1'b0;
        if (do_load) begin
            ser_load = 1'b1;
            @(negedge clk);
            ser_load = 1'b0;
        end
    endtask

    task automatic advance(input int n, input logic [NCH-1:0] chm);
        for (int k = 0; k < n; k++) begin
            ref_tick    = 1'b1;
            ch_ref_tick = chm;
            @(negedge clk);
        end
        ref_tick    = 1'b0;
        ch_ref_tick = '0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset outputs low", lo_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1/R4/R5 (plus R6 and R7 where codes or masks call for it)
        for (int v = 0; v < NVEC; v++) begin
            set_mode(VECS[v].mode);
            program_cfg(VECS[v].base, 3, VECS[v].offm, 1'b1);
            advance(int'(VECS[v].steps) + 1, '1);
            for (int c = 0; c < NCH; c++) cur_steps[c] = int'(VECS[v].steps);
            check($sformatf("R1/R4/R5 vector %0d", v), lo_out, expect_lo(VECS[v].mode));
        end

        // R2: chain order, only channel 0 enabled, then only channel 7
        set_mode(2'b00);
        program_cfg(4'd8, 0, 8'hFE, 1'b1);
        advance(1, '1);
        check("R2 channel 0 word position", lo_out, 8'h01);
        program_cfg(4'd8, 0, 8'h7F, 1'b1);
        advance(1, '1);
        check("R2 channel 7 word position", lo_out, 8'h80);

        // R3: shifting without load changes nothing
        program_cfg(4'd0, 0, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        check("R3 shift without load", lo_out, 8'h80);

        // R6: unused phase MSB ignored in mode 01
        set_mode(2'b01);
        program_cfg(4'b1011, 0, 8'h00, 1'b1);
        advance(3, '1);
        for (int c = 0; c < NCH; c++) cur_steps[c] = 2;
        check("R6 mode 01 MSB set", lo_out, 8'hFF);
        program_cfg(4'b0011, 0, 8'h00, 1'b1);
        advance(3, '1);
        check("R6 mode 01 MSB clear", lo_out, 8'hFF);

        // R6: two MSBs ignored in mode 10 (code 1110 acts as 10)
        set_mode(2'b10);
        program_cfg(4'b1110, 0, 8'h00, 1'b1);
        advance(1, '1);
        for (int c = 0; c < NCH; c++) cur_steps[c] = 0;
        check("R6 mode 10 upper bits", lo_out, 8'hFF);

        // R8: lone channel advance in mode 10
        program_cfg(4'd2, 1, 8'h00, 1'b1);
        advance(4, '1);
        for (int c = 0; c < NCH; c++) cur_steps[c] = 3;
        check("R8 all channels 3 advances", lo_out, expect_lo(2'b10));
        advance(1, 8'h04);
        cur_steps[2] = 4;
        check("R8 only channel 2 advanced", lo_out, expect_lo(2'b10));

        // R4: mode change re-presets without reload
        set_mode(2'b00);
        advance(1, '0);
        for (int c = 0; c < NCH; c++) cur_steps[c] = 0;
        check("R4 preset after mode change", lo_out, expect_lo(2'b00));
        advance(9, '0);
        for (int c = 0; c < NCH; c++) cur_steps[c] = 9;
        check("R4 count after mode change", lo_out, expect_lo(2'b00));

        // R9 and R7: bypass mode follows quad_clk, gated by shutdown
        set_mode(2'b11);
        program_cfg(4'd0, 0, 8'h0F, 1'b1);
        quad_clk = 8'h5A;
        @(negedge clk);
        check("R9 bypass pattern 5A", lo_out, 8'h50);
        quad_clk = 8'hFF;
        @(negedge clk);
        check("R7 bypass shutdown gating", lo_out, 8'hF0);

        // R10: reset in the middle of operation
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 mid-run reset", lo_out, 8'h00);
        rst_n = 1'b1;
        quad_clk = '0;
        @(negedge clk);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule